// File: doc/BRIEF.md
# Slave-Mode Counter with Quadrature Decoding

This block is a wrapping up/down counter whose clocking and control come from a 3-bit mode code. The mode decides what moves the count. It can be the internal clock, or edges on either or both of two quadrature channels. It can also be a trigger input, which may reset the count, gate it, start it, or clock it one step per edge. The count wraps between zero and an auto-reload bound. A one-cycle update pulse marks every wrap and every reset caused by the trigger.

The inputs must already be filtered and synchronized to the block clock. Trigger source selection, prescaling and filtering are done outside the block. Edges are found by comparing each input with its value one clock earlier. The edge-detect history registers clear to zero at reset, and they update every cycle in every mode. The counter reacts on the same clock edge at which an input edge is first sampled.

Top module: `tmr_slave_ctrl`

## Requirements
- R1: During and after reset, before any stimulus, cnt_o is 0, dir_o is 0 (up) and upd_o is 0.
- R2: With mode code 0 and cnt_en_i high, the count rises by one on every clock. With cnt_en_i low, it holds.
- R3: Mode code 1 counts only on changes of ti2_i, and changes of ti1_i alone are ignored. The step is up when the new ti2_i equals ti1_i, and down otherwise.
- R4: Mode code 2 counts only on changes of ti1_i, and changes of ti2_i alone are ignored. The step is up when the new ti1_i differs from ti2_i, and down otherwise.
- R5: Mode code 3 counts on a change of either channel, using the R3 and R4 direction rules, which gives four counts per quadrature cycle. If both channels change in the same cycle, the count does not move.
- R6: In modes 1 to 3 no count happens while cnt_en_i is low. dir_o becomes 1 after an encoder down step and 0 after an encoder up step, and otherwise keeps its value.
- R7: Counting up from a value greater than or equal to arr_i gives 0. Counting down from 0 gives arr_i. Each such wrap raises upd_o for exactly the following cycle.
- R8: In mode code 4, a rising edge of trgi_i sets the count to 0 and pulses upd_o, whatever cnt_en_i is. In other cycles the block counts as in R2.
- R9: In mode code 5 the count rises by one per clock only while both cnt_en_i and trgi_i are high. Otherwise it keeps its value.
- R10: In mode code 6, a rising edge of trgi_i starts counting up on every clock, beginning in the cycle of that edge, without resetting the count. After that, trgi_i and cnt_en_i have no effect. The run state clears when the mode code changes away from 6.
- R11: In mode code 7 with cnt_en_i high, each rising edge of trgi_i adds one to the count. Nothing else moves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Slave-mode code 0..7 |
| cnt_en_i | input | 1 | Counter enable |
| ti1_i | input | 1 | Quadrature channel 1 level |
| ti2_i | input | 1 | Quadrature channel 2 level |
| trgi_i | input | 1 | Selected trigger level |
| arr_i | input | 16 | Auto-reload bound |
| cnt_o | output | 16 | Current count |
| dir_o | output | 1 | Direction of last encoder step, 1 = down |
| upd_o | output | 1 | One-cycle update pulse |

## Verification
The embedded properties check on every cycle that the count holds wherever a mode forbids motion: a disabled encoder, a gated-off trigger, or an external-clock cycle with no trigger edge. They also check that a trigger reset lands at zero with an update pulse, that every update pulse leaves the count at zero or at the bound, and that a simultaneous double change in x4 mode is dropped. The Gray-code direction rules, the exact counts over full quadrature cycles, the wrap values, and the latched start of mode 6 can only be shown by the bench scenarios. In those scenarios a behavioural model and hand-computed end values are compared against the ports.

// File: rtl/tmr_slave_pkg.sv
package tmr_slave_pkg;

    typedef enum logic [2:0] {
        SM_FREE   = 3'd0,
        SM_ENC_B  = 3'd1,
        SM_ENC_A  = 3'd2,
        SM_ENC_AB = 3'd3,
        SM_RESET  = 3'd4,
        SM_GATED  = 3'd5,
        SM_START  = 3'd6,
        SM_EXTCLK = 3'd7
    } smode_e;

    localparam int unsigned NUM_SENSE = 3;  // ti1, ti2, trgi
    localparam int unsigned SNS_TI1   = 0;
    localparam int unsigned SNS_TI2   = 1;
    localparam int unsigned SNS_TRG   = 2;

endpackage

// File: rtl/tmr_edge_hist.sv
module tmr_edge_hist #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] chg_o,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_sense
        assign chg_o[g]  = lvl_i[g] ^ prev_q[g];
        assign rise_o[g] = lvl_i[g] & ~prev_q[g];
    end

endmodule

// File: rtl/tmr_quad_dec.sv
module tmr_quad_dec (
    input  logic use_a_i,   // count on channel 1 changes
    input  logic use_b_i,   // count on channel 2 changes
    input  logic ti1_i,
    input  logic ti2_i,
    input  logic chg1_i,
    input  logic chg2_i,
    output logic up_o,
    output logic dn_o
);

    logic a_ok, b_ok, a_up, b_up;

    always_comb begin
        // both channels moving at once carries no direction information
        a_ok = use_a_i & chg1_i & ~(use_b_i & chg2_i);
        b_ok = use_b_i & chg2_i & ~(use_a_i & chg1_i);
        a_up = ti1_i ^ ti2_i;
        b_up = ~(ti1_i ^ ti2_i);
        up_o = (a_ok & a_up) | (b_ok & b_up);
        dn_o = (a_ok & ~a_up) | (b_ok & ~b_up);
    end

endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         dec_i,
    input  logic         clr_i,
    input  logic         dir_we_i,
    input  logic         dir_i,
    input  logic [W-1:0] arr_i,
    output logic [W-1:0] cnt_o,
    output logic         dir_o,
    output logic         upd_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         dir;
        logic         upd;
    } core_t;

    localparam logic [W-1:0] ONE = W'(1);

    core_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (clr_i) begin
            st_d.cnt = '0;
            st_d.upd = 1'b1;
        end else if (inc_i) begin
            if (st_q.cnt >= arr_i) begin
                st_d.cnt = '0;
                st_d.upd = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end else if (dec_i) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = arr_i;
                st_d.upd = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
        if (dir_we_i) st_d.dir = dir_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign dir_o = st_q.dir;
    assign upd_o = st_q.upd;

    AST_UPD_AT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.upd |-> (st_q.cnt == '0 || st_q.cnt == $past(arr_i))); // R7
    AST_ONE_STEP_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inc_i, dec_i})); // R6

endmodule

// File: rtl/tmr_slave_ctrl.sv
module tmr_slave_ctrl
    import tmr_slave_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic             cnt_en_i,
    input  logic             ti1_i,
    input  logic             ti2_i,
    input  logic             trgi_i,
    input  logic [CNT_W-1:0] arr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_o,
    output logic             upd_o
);

    typedef struct packed {
        logic run;
    } ctl_t;

    smode_e               mode;
    logic [NUM_SENSE-1:0] lvl, chg, rise;
    logic                 trg_rise;
    logic                 use_a, use_b, q_up, q_dn;
    logic                 inc, dec, clr, dir_we, dir_val;
    ctl_t                 ctl_d, ctl_q;

    assign mode          = smode_e'(mode_i);
    assign lvl[SNS_TI1]  = ti1_i;
    assign lvl[SNS_TI2]  = ti2_i;
    assign lvl[SNS_TRG]  = trgi_i;
    assign trg_rise      = rise[SNS_TRG];

    tmr_edge_hist #(.N(NUM_SENSE)) i_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl),
        .chg_o  (chg),
        .rise_o (rise)
    );

    assign use_a = (mode == SM_ENC_A) || (mode == SM_ENC_AB);
    assign use_b = (mode == SM_ENC_B) || (mode == SM_ENC_AB);

    tmr_quad_dec i_quad (
        .use_a_i (use_a),
        .use_b_i (use_b),
        .ti1_i   (ti1_i),
        .ti2_i   (ti2_i),
        .chg1_i  (chg[SNS_TI1]),
        .chg2_i  (chg[SNS_TI2]),
        .up_o    (q_up),
        .dn_o    (q_dn)
    );

    always_comb begin
        ctl_d   = ctl_q;
        inc     = 1'b0;
        dec     = 1'b0;
        clr     = 1'b0;
        dir_we  = 1'b0;
        dir_val = 1'b0;
        unique case (mode)
            SM_FREE:  inc = cnt_en_i;
            SM_ENC_B, SM_ENC_A, SM_ENC_AB: begin
                inc     = cnt_en_i & q_up;
                dec     = cnt_en_i & q_dn;
                dir_we  = inc | dec;
                dir_val = dec;
            end
            SM_RESET: begin
                clr = trg_rise;
                inc = cnt_en_i & ~trg_rise;
            end
            SM_GATED:  inc = cnt_en_i & trgi_i;
            SM_START:  inc = ctl_q.run | trg_rise;
            SM_EXTCLK: inc = cnt_en_i & trg_rise;
            default:   inc = 1'b0;
        endcase
        ctl_d.run = (mode == SM_START) & (ctl_q.run | trg_rise);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    tmr_cnt_core #(.W(CNT_W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (inc),
        .dec_i    (dec),
        .clr_i    (clr),
        .dir_we_i (dir_we),
        .dir_i    (dir_val),
        .arr_i    (arr_i),
        .cnt_o    (cnt_o),
        .dir_o    (dir_o),
        .upd_o    (upd_o)
    );

    AST_TRG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SM_RESET && trg_rise) |=> (cnt_o == '0 && upd_o)); // R8
    AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SM_GATED && !trgi_i) |=> $stable(cnt_o)); // R9
    AST_ENC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (use_a | use_b) && !cnt_en_i |=> ($stable(cnt_o) && $stable(dir_o))); // R6
    AST_EXT_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SM_EXTCLK && !trg_rise) |=> $stable(cnt_o)); // R11
    AST_X4_DOUBLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SM_ENC_AB && chg[SNS_TI1] && chg[SNS_TI2]) |-> !(q_up || q_dn)); // R5

endmodule

// File: tb/test_tmr_slave_ctrl.sv
`timescale 1ns/1ps
module test_tmr_slave_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        en = 1'b0, ti1 = 1'b0, ti2 = 1'b0, trg = 1'b0;
    logic [15:0] arr = 16'd5;
    logic [15:0] cnt;
    logic        dir, upd;

    int checks = 0, fails = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural reference
    int m_cnt = 0, m_dir = 0, m_upd = 0;
    bit p1 = 0, p2 = 0, pt = 0, run = 0;
    int gray = 0;

    always #2.5 clk = ~clk;

    tmr_slave_ctrl i_tmr_slave_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .cnt_en_i(en),
        .ti1_i(ti1), .ti2_i(ti2), .trgi_i(trg), .arr_i(arr),
        .cnt_o(cnt), .dir_o(dir), .upd_o(upd)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_dir = 0; m_upd = 0; p1 = 0; p2 = 0; pt = 0; run = 0;
        end else begin
            bit r, e1, e2, up, dn, cl;
            r = trg && !pt; e1 = (ti1 != p1); e2 = (ti2 != p2);
            up = 0; dn = 0; cl = 0;
            case (mode)
                3'd0: up = en;
                3'd1: if (en && e2) begin if (ti2 == ti1) up = 1; else dn = 1; end
                3'd2: if (en && e1) begin if (ti1 != ti2) up = 1; else dn = 1; end
                3'd3: if (en && (e1 != e2)) begin
                          if (e1) begin if (ti1 != ti2) up = 1; else dn = 1; end
                          else    begin if (ti2 == ti1) up = 1; else dn = 1; end
                      end
                3'd4: if (r) cl = 1; else up = en;
                3'd5: up = en && trg;
                3'd6: up = run || r;
                default: up = en && r;
            endcase
            run = (mode == 3'd6) && (run || r);
            m_upd = 0;
            if (cl) begin m_cnt = 0; m_upd = 1; end
            else if (up) begin
                if (m_cnt >= int'(arr)) begin m_cnt = 0; m_upd = 1; end
                else m_cnt++;
            end else if (dn) begin
                if (m_cnt == 0) begin m_cnt = int'(arr); m_upd = 1; end
                else m_cnt--;
            end
            if (mode >= 3'd1 && mode <= 3'd3 && (up || dn)) m_dir = dn ? 1 : 0;
            p1 = ti1; p2 = ti2; pt = trg;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (int'(cnt) != m_cnt || int'(dir) != m_dir || int'(upd) != m_upd) begin
                fails++;
                $display("FAIL %s model: cnt=%0d dir=%0d upd=%0d expected cnt=%0d dir=%0d upd=%0d",
                         cur_req, cnt, dir, upd, m_cnt, m_dir, m_upd);
            end
        end
    end

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_val(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic zero_cnt();
        en = 0; mode = 3'd4; trg = 1; tick(1); trg = 0; tick(1);
    endtask

    // walk the Gray cycle 00,10,11,01 one phase per clock
    task automatic quad(bit fwd, int n);
        for (int i = 0; i < n; i++) begin
            gray = fwd ? (gray + 1) % 4 : (gray + 3) % 4;
            ti1 = (gray == 1 || gray == 2);
            ti2 = (gray == 2 || gray == 3);
            tick(1);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        expect_val("R1 cnt", int'(cnt), 0);
        expect_val("R1 dir", int'(dir), 0);
        expect_val("R1 upd", int'(upd), 0);
        rst_n = 1; tick(1);
        expect_val("R1 cnt after release", int'(cnt), 0);

        cur_req = "R2"; mode = 3'd0; en = 1; tick(8);
        expect_val("R2 R7 free run wrap", int'(cnt), 2);
        en = 0; tick(3);
        expect_val("R2 hold", int'(cnt), 2);

        cur_req = "R8"; zero_cnt();
        expect_val("R8 trigger clear", int'(cnt), 0);
        en = 1; tick(3); trg = 1; tick(1);
        expect_val("R8 clear while enabled", int'(cnt), 0);
        expect_val("R8 update pulse", int'(upd), 1);
        trg = 0; tick(2);

        arr = 16'd100;
        cur_req = "R3"; zero_cnt(); mode = 3'd1; en = 1;
        quad(1, 4);
        expect_val("R3 x2 up", int'(cnt), 2);
        quad(0, 4);
        expect_val("R3 back down", int'(cnt), 0);
        expect_val("R6 dir down", int'(dir), 1);
        cur_req = "R7"; quad(0, 4);
        expect_val("R7 underflow to bound", int'(cnt), 99);

        cur_req = "R4"; zero_cnt(); mode = 3'd2; en = 1;
        quad(1, 4);
        expect_val("R4 x2 up", int'(cnt), 2);
        expect_val("R6 dir up", int'(dir), 0);

        cur_req = "R5"; zero_cnt(); mode = 3'd3; en = 1;
        quad(1, 4);
        expect_val("R5 x4 up", int'(cnt), 4);
        quad(0, 2);
        expect_val("R5 x4 down", int'(cnt), 2);
        ti1 = ~ti1; ti2 = ~ti2; gray = (gray + 2) % 4; tick(2);
        expect_val("R5 double change dropped", int'(cnt), 2);
        cur_req = "R6"; en = 0; quad(1, 6);
        expect_val("R6 encoder disabled", int'(cnt), 2);

        cur_req = "R9"; zero_cnt(); mode = 3'd5; en = 1; trg = 1; tick(3);
        trg = 0; tick(3);
        expect_val("R9 gated", int'(cnt), 3);
        en = 0; trg = 1; tick(2);
        expect_val("R9 needs enable", int'(cnt), 3);
        trg = 0; tick(1);

        cur_req = "R10"; zero_cnt(); mode = 3'd6; en = 0; tick(3);
        expect_val("R10 idle before start", int'(cnt), 0);
        trg = 1; tick(1); trg = 0; tick(4);
        expect_val("R10 latched start", int'(cnt), 5);
        mode = 3'd0; tick(1); mode = 3'd6; tick(2);
        expect_val("R10 run cleared on mode exit", int'(cnt), 5);

        cur_req = "R11"; zero_cnt(); mode = 3'd7; en = 1;
        for (int k = 0; k < 3; k++) begin trg = 1; tick(2); trg = 0; tick(1); end
        expect_val("R11 one per edge", int'(cnt), 3);

        cur_req = "R7"; arr = 16'd3; zero_cnt(); mode = 3'd0; en = 1; tick(4);
        expect_val("R7 wrap to zero", int'(cnt), 0);
        expect_val("R7 wrap pulse", int'(upd), 1);
        tick(1);
        expect_val("R7 pulse one cycle", int'(upd), 0);
        en = 0; arr = 16'd100; tick(1); arr = 16'd0; en = 1; tick(1);
        expect_val("R7 above bound wraps", int'(cnt), 0);
        en = 0; tick(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule